// File: doc/BRIEF.md
# Staged Bit-Permutation Unit

This block rearranges the bits of a 64-bit word. It offers four operations: generalized bit reversal, OR-combine, perfect shuffle and perfect unshuffle. A control amount picks which strides take part. Each control bit turns on one stage of a staged network. A reversal stage of stride 2^k swaps neighbouring blocks of 2^k bits. An OR-combine stage merges the swapped copy into the word instead of replacing it. A shuffle stage exchanges the second and third quarters of every group of 4*2^k bits.

A narrow word mode works on the low 32 bits only. The same network is used, with the widest stride of each family disabled. The operand is presented with `in_valid`, and the result appears one clock later on `data_out`. The result register holds its value between operands.

Top module: `bitperm_unit`

## Requirements
- R1: While reset is asserted and after it is released, `out_valid` is 0 and `data_out` is 0 until the first operand is accepted.
- R2: `out_valid` is `in_valid` delayed by exactly one clock. `data_out` keeps its value in any cycle that follows a cycle without `in_valid`.
- R3: Reversal is selected by `op` = 2'b00. Result bit i equals input bit (i XOR c), where c is `ctrl` (6 bits in 64-bit mode). Control bit k swaps adjacent blocks of 2^k bits.
- R4: OR-combine is selected by `op` = 2'b01. Result bit i is the OR of every input bit j for which (i XOR j) has ones only where c has ones.
- R5: Shuffle is selected by `op` = 2'b10. In 64-bit mode only `ctrl[4:0]` is used. The stage of bit k swaps index bits k and k+1 of every bit position, and the stages run from k=4 down to k=0. `ctrl[5]` has no effect.
- R6: Unshuffle is selected by `op` = 2'b11. It runs the same stages from k=0 up to k=4, so unshuffling a shuffled word with the same control gives back the original word.
- R7: When `word_mode` is 1, the result depends only on `data_in[31:0]` and `data_out[63:32]` is 0. Reversal and OR-combine use `ctrl[4:0]`. Shuffle and unshuffle use `ctrl[3:0]`.
- R8: A control amount of zero passes the (word-mode-trimmed) input through unchanged for every operation.
- R9: Reversal applied twice with the same control gives back the original word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operand present this cycle |
| op | input | 2 | 00 reversal, 01 OR-combine, 10 shuffle, 11 unshuffle |
| word_mode | input | 1 | 1 selects the 32-bit form on the low half |
| ctrl | input | 6 | Control amount; each bit enables one stride |
| data_in | input | 64 | Word to permute |
| out_valid | output | 1 | Result present this cycle |
| data_out | output | 64 | Permuted word |

## Verification
Word-mode trimming and the top control bit can act on the same operand. With `word_mode` set and `ctrl[5]` (or `ctrl[4]` for shuffle) also set, both would try to move data across the 32-bit boundary. The bench drives such operands with nonzero upper input bits. It judges them against a model that first trims the input and control, and then checks that the upper result half is zero. Back-to-back operands of different families, fed every cycle, also make sure that the OR-accumulate flag of one operand never leaks into the next.

// File: rtl/bitperm_pkg.sv
package bitperm_pkg;
  localparam int unsigned XW = 64;
  localparam int unsigned CW = $clog2(XW);
  localparam int unsigned HW = XW / 2;

  typedef enum logic [1:0] {
    OP_REV = 2'b00,
    OP_ORC = 2'b01,
    OP_SHF = 2'b10,
    OP_UNS = 2'b11
  } perm_op_e;

  // ones on the lower block of every pair of blocks of size s
  function automatic logic [XW-1:0] pair_low_mask(input int s);
    logic [XW-1:0] m;
    for (int i = 0; i < XW; i++) m[i] = ((i / s) % 2) == 0;
    return m;
  endfunction

  // quarter q of every group of 4*s bits
  function automatic logic [XW-1:0] quarter_mask(input int s, input int q);
    logic [XW-1:0] m;
    for (int i = 0; i < XW; i++) m[i] = ((i / s) % 4) == q;
    return m;
  endfunction

  function automatic logic [XW-1:0] butterfly_step(input logic [XW-1:0] x,
                                                   input int s, input logic acc);
    logic [XW-1:0] lo, moved;
    lo    = pair_low_mask(s);
    moved = ((x & lo) << s) | ((x & ~lo) >> s);
    return acc ? (x | moved) : moved;
  endfunction

  function automatic logic [XW-1:0] interleave_step(input logic [XW-1:0] x, input int s);
    logic [XW-1:0] up, dn;
    up = quarter_mask(s, 2);
    dn = quarter_mask(s, 1);
    return (x & ~(up | dn)) | ((x << s) & up) | ((x >> s) & dn);
  endfunction
endpackage

// File: rtl/bitperm_ctl.sv
module bitperm_ctl
  import bitperm_pkg::*;
(
  input  logic [1:0]    op,
  input  logic          word_mode,
  input  logic [CW-1:0] ctrl,
  input  logic [XW-1:0] data_in,
  output logic [CW-1:0] bf_en,
  output logic [CW-2:0] sh_en,
  output logic          accum,
  output logic [XW-1:0] src_eff
);
  always_comb begin
    accum   = (perm_op_e'(op) == OP_ORC);
    bf_en   = ctrl;
    sh_en   = ctrl[CW-2:0];
    src_eff = data_in;
    if (word_mode) begin
      bf_en[CW-1]       = 1'b0;
      sh_en[CW-2]       = 1'b0;
      src_eff[XW-1:HW]  = '0;
    end
  end
endmodule

// File: rtl/bitperm_net.sv
module bitperm_net
  import bitperm_pkg::*;
(
  input  logic [XW-1:0] src,
  input  logic [CW-1:0] bf_en,
  input  logic [CW-2:0] sh_en,
  input  logic          accum,
  output logic [XW-1:0] bf_res,
  output logic [XW-1:0] shf_res,
  output logic [XW-1:0] uns_res
);
  localparam int unsigned NSH = CW - 1;

  logic [XW-1:0] bf_w [0:CW];
  logic [XW-1:0] sf_w [0:NSH];
  logic [XW-1:0] us_w [0:NSH];

  assign bf_w[0] = src;
  assign sf_w[0] = src;
  assign us_w[0] = src;

  for (genvar k = 0; k < CW; k++) begin : g_bfly
    assign bf_w[k+1] = bf_en[k] ? butterfly_step(bf_w[k], 1 << k, accum) : bf_w[k];
  end

  for (genvar p = 0; p < NSH; p++) begin : g_shuf
    localparam int KF = NSH - 1 - p;
    assign sf_w[p+1] = sh_en[KF] ? interleave_step(sf_w[p], 1 << KF) : sf_w[p];
    assign us_w[p+1] = sh_en[p]  ? interleave_step(us_w[p], 1 << p)  : us_w[p];
  end

  assign bf_res  = bf_w[CW];
  assign shf_res = sf_w[NSH];
  assign uns_res = us_w[NSH];
endmodule

// File: rtl/bitperm_unit.sv
module bitperm_unit
  import bitperm_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [1:0]    op,
  input  logic          word_mode,
  input  logic [CW-1:0] ctrl,
  input  logic [XW-1:0] data_in,
  output logic          out_valid,
  output logic [XW-1:0] data_out
);
  logic [CW-1:0] bf_en;
  logic [CW-2:0] sh_en;
  logic          accum;
  logic [XW-1:0] src_eff, bf_res, shf_res, uns_res, perm_result;

  bitperm_ctl u_ctl (
    .op(op), .word_mode(word_mode), .ctrl(ctrl), .data_in(data_in),
    .bf_en(bf_en), .sh_en(sh_en), .accum(accum), .src_eff(src_eff)
  );

  bitperm_net u_net (
    .src(src_eff), .bf_en(bf_en), .sh_en(sh_en), .accum(accum),
    .bf_res(bf_res), .shf_res(shf_res), .uns_res(uns_res)
  );

  always_comb begin
    case (perm_op_e'(op))
      OP_SHF:  perm_result = shf_res;
      OP_UNS:  perm_result = uns_res;
      default: perm_result = bf_res;
    endcase
    if (word_mode) perm_result[XW-1:HW] = '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      data_out  <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) data_out <= perm_result;
    end
  end
endmodule

// File: rtl/bitperm_unit_chk.sv
module bitperm_unit_chk
  import bitperm_pkg::*;
(
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic [1:0]    op,
  input logic          word_mode,
  input logic [CW-1:0] ctrl,
  input logic [XW-1:0] data_in,
  input logic          out_valid,
  input logic [XW-1:0] data_out
);
  // R2
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  // R2
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid && $stable(data_out));
  // R7
  word_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && word_mode |=> data_out[XW-1:HW] == '0);
  // R8
  zero_ctrl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && !word_mode && ctrl == '0 |=> data_out == $past(data_in));
  // R4
  orc_cover_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && !word_mode && op == 2'b01 |=> (data_out & $past(data_in)) == $past(data_in));
  // R3
  perm_weight_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && !word_mode && op != 2'b01 |=> $countones(data_out) == $countones($past(data_in)));
endmodule

bind bitperm_unit bitperm_unit_chk u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op), .word_mode(word_mode),
  .ctrl(ctrl), .data_in(data_in), .out_valid(out_valid), .data_out(data_out)
);

// File: tb/bitperm_unit_test.sv
`timescale 1ns/1ps
module bitperm_unit_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [1:0]  op = 2'b00;
  logic        word_mode = 1'b0;
  logic [5:0]  ctrl = '0;
  logic [63:0] data_in = '0;
  logic        out_valid;
  logic [63:0] data_out;

  int total = 0;
  int bad = 0;
  bit done = 0;
  logic [63:0] exp_q[$];
  string       tag_q[$];

  always #2 clk = ~clk;

  bitperm_unit uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op), .word_mode(word_mode),
    .ctrl(ctrl), .data_in(data_in), .out_valid(out_valid), .data_out(data_out)
  );

  // ---------- reference model (index form) ----------
  function automatic logic [63:0] trim(logic [63:0] x, bit w);
    return w ? {32'h0, x[31:0]} : x;
  endfunction

  function automatic logic [63:0] m_rev(logic [63:0] x, logic [5:0] c, bit w);
    logic [63:0] r = '0;
    int n = w ? 32 : 64;
    int cc = w ? int'(c) & 31 : int'(c);
    x = trim(x, w);
    for (int i = 0; i < n; i++) r[i] = x[i ^ cc];
    return r;
  endfunction

  function automatic logic [63:0] m_orc(logic [63:0] x, logic [5:0] c, bit w);
    logic [63:0] r = '0;
    int n = w ? 32 : 64;
    int cc = w ? int'(c) & 31 : int'(c);
    x = trim(x, w);
    for (int i = 0; i < n; i++)
      for (int j = 0; j < n; j++)
        if (((i ^ j) & ~cc) == 0 && x[j]) r[i] = 1'b1;
    return r;
  endfunction

  function automatic int swp(int i, int k);
    int a = (i >> k) & 1;
    int b = (i >> (k + 1)) & 1;
    int r = i & ~((1 << k) | (1 << (k + 1)));
    return r | (a << (k + 1)) | (b << k);
  endfunction

  function automatic logic [63:0] m_shf(logic [63:0] x, logic [5:0] c, bit w, bit inv);
    logic [63:0] y;
    int n = w ? 4 : 5;
    x = trim(x, w);
    for (int s = 0; s < n; s++) begin
      int k = inv ? s : n - 1 - s;
      if (c[k]) begin
        for (int i = 0; i < 64; i++) y[i] = x[swp(i, k)];
        x = y;
      end
    end
    return x;
  endfunction

  function automatic logic [63:0] model(logic [1:0] o, logic [63:0] x, logic [5:0] c, bit w);
    case (o)
      2'b00: return m_rev(x, c, w);
      2'b01: return m_orc(x, c, w);
      2'b10: return m_shf(x, c, w, 1'b0);
      default: return m_shf(x, c, w, 1'b1);
    endcase
  endfunction

  function automatic logic [63:0] rnd64();
    return {$urandom(), $urandom()};
  endfunction

  // ---------- checking ----------
  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic send(logic [1:0] o, bit w, logic [63:0] d, logic [5:0] c,
                      logic [63:0] e, string req);
    @(negedge clk);
    in_valid = 1'b1; op = o; word_mode = w; data_in = d; ctrl = c;
    exp_q.push_back(e);
    tag_q.push_back(req);
  endtask

  task automatic idle();
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  // monitor: result of the operand driven at one falling edge is sampled at the next
  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      if (exp_q.size() == 0) begin
        total++; bad++;
        $display("FAIL R2 unexpected result act=%h exp=none", data_out);
      end else begin
        check(tag_q.pop_front(), data_out, exp_q.pop_front());
      end
    end
  end

  initial begin
    logic [63:0] x, y, last;
    repeat (3) @(posedge clk);
    // R1: state during reset
    check("R1 valid in reset", {63'h0, out_valid}, 64'h0);
    check("R1 data in reset", data_out, 64'h0);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    check("R1 valid after reset", {63'h0, out_valid}, 64'h0);
    check("R1 data after reset", data_out, 64'h0);

    // R3 hand-computed: byte reversal and full reversal
    send(2'b00, 0, 64'h0123456789abcdef, 6'b111000, 64'hefcdab8967452301, "R3 byte rev");
    send(2'b00, 0, 64'h0000000000000001, 6'h3f, 64'h8000000000000000, "R3 full rev");
    // R4 hand-computed: byte-wise OR
    send(2'b01, 0, 64'h0000010000800000, 6'h07, 64'h0000ff0000ff0000, "R4 byte orc");
    // R5 hand-computed: stride-1 stage moves bit 2 to bit 1
    send(2'b10, 0, 64'h0000000000000004, 6'h01, 64'h0000000000000002, "R5 stride1");
    // R5 ctrl[5] ignored
    x = rnd64();
    send(2'b10, 0, x, 6'h21, m_shf(x, 6'h01, 0, 0), "R5 top ctrl bit ignored");
    send(2'b11, 0, x, 6'h3f, m_shf(x, 6'h1f, 0, 1), "R6 top ctrl bit ignored");
    // R7 hand-computed word reversal with dirty upper half
    send(2'b00, 1, 64'hdeadbeef00000001, 6'h3f, 64'h0000000080000000, "R7 word rev");
    // R7 word-mode widest stride combined with top ctrl bits
    for (int o = 0; o < 4; o++) begin
      x = rnd64();
      send(2'(o), 1, x, 6'h3f, model(2'(o), x, 6'h3f, 1), "R7 word full ctrl");
    end
    // R8 zero control every op
    for (int o = 0; o < 4; o++) begin
      x = rnd64();
      send(2'(o), 0, x, 6'h00, x, "R8 zero ctrl");
      send(2'(o), 1, x, 6'h00, trim(x, 1), "R8 zero ctrl word");
    end
    // R3 R4 R5 R6 R7 random, back-to-back mixed families
    for (int n = 0; n < 160; n++) begin
      logic [1:0] o = 2'($urandom_range(0, 3));
      bit w = ($urandom_range(0, 3) == 0);
      logic [5:0] c = 6'($urandom());
      x = rnd64();
      send(o, w, x, c, model(o, x, c, w),
           o == 2'b00 ? (w ? "R7 rev" : "R3 rev") :
           o == 2'b01 ? (w ? "R7 orc" : "R4 orc") :
           o == 2'b10 ? (w ? "R7 shf" : "R5 shf") : (w ? "R7 uns" : "R6 uns"));
    end
    idle();
    // R6 and R9 round trips through the design
    for (int n = 0; n < 12; n++) begin
      logic [5:0] c = 6'($urandom());
      bit w = n[0];
      x = rnd64();
      send(2'b10, w, x, c, model(2'b10, x, c, w), "R5 shf");
      idle();
      y = data_out;
      send(2'b11, w, y, c, trim(x, w), "R6 round trip");
      idle();
      send(2'b00, w, x, c, model(2'b00, x, c, w), "R3 rev");
      idle();
      y = data_out;
      send(2'b00, w, y, c, trim(x, w), "R9 double rev");
      idle();
    end
    // R2 hold with no operand
    @(negedge clk);
    last = data_out;
    repeat (3) @(negedge clk);
    check("R2 hold data", data_out, last);
    check("R2 valid low", {63'h0, out_valid}, 64'h0);
    check("R2 queue drained", 64'(exp_q.size()), 64'h0);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule